// File: doc/BRIEF.md
# Multi-Port Micro-Op Issue Scheduler

This block is a small reservation station that sits between the front end and six execution ports. The front end writes one micro-op per cycle into a free slot. Each micro-op carries an operation class and an opaque payload. External wakeup logic drives one ready bit per slot. In every cycle the scheduler looks at the ready entries. For each port it picks the oldest ready entry whose class may run on that port. It then presents the chosen payload on that port's issue outputs, unless the port is stalled.

Ports 0, 1 and 5 execute arithmetic, and ports 2, 3 and 4 serve memory traffic. Class routing is fixed and asymmetric. Plain integer and vector-integer work may use any arithmetic port. Other classes are tied to a single port: wide multiply and all floating-point multiply go to port 0, shift/rotate/narrow multiply and all floating-point add go to port 1, and branches go to port 5. Load, store-address and store-data each have their own memory port. Issue is combinational from the station state, and an issued slot is released at the next clock edge.

Top module: `uop_issue_sched`

## Requirements
- R1: An allocation is accepted when `alloc_valid` and `alloc_ready` are both high. The new entry takes the lowest-numbered free slot, which `alloc_slot` reports in that cycle. `alloc_ready` is low exactly when every slot is occupied, and a refused allocation creates no entry.
- R2: Each port issues at most one micro-op per cycle, and no entry is issued to more than one port in the same cycle.
- R3: The class codes are 0 simple integer, 1 vector integer, 2 wide integer multiply, 3 shift/rotate/narrow multiply, 4 floating-point multiply, 5 floating-point add, 6 branch, 7 load, 8 store address and 9 store data. Codes 10 to 15 are eligible for no port. Class 7 issues only on port 2, class 8 only on port 3, and class 9 only on port 4.
- R4: Classes 2 and 4 issue only on port 0.
- R5: Classes 3 and 5 issue only on port 1.
- R6: Class 6 issues only on port 5. Classes 0 and 1 may issue on port 0, 1 or 5.
- R7: Among the ready entries eligible for a port and still available to it, the one allocated earliest is issued.
- R8: Ports choose in the fixed order 0, 1, 5, 2, 3, 4. An entry issued by an earlier port in this order is not offered to later ports in the same cycle.
- R9: A port whose `iss_stall` bit is high issues nothing. The entry it would have taken stays in the station and remains available to later ports in the order.
- R10: An entry whose `entry_ready` bit is low is not issued.
- R11: An issued entry leaves the station at the next clock edge. Its slot can be allocated from the following cycle, but not in the cycle in which it issues.
- R12: After reset the station is empty, `alloc_ready` is high and no port issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Front end offers a micro-op |
| alloc_class | input | 4 | Operation class of the offered micro-op |
| alloc_payload | input | PAYLOAD_W | Opaque micro-op payload |
| alloc_ready | output | 1 | A slot is free this cycle |
| alloc_slot | output | $clog2(ENTRIES) | Slot the offered micro-op will occupy |
| entry_ready | input | ENTRIES | Per-slot operands-ready bits |
| iss_stall | input | 6 | Per-port stall |
| iss_valid | output | 6 | Per-port issue valid |
| iss_payload | output | 6 x PAYLOAD_W | Per-port issued payload |

## Verification
The bench builds the scheduler with ENTRIES=4 and PAYLOAD_W=12. With only four slots, a run of four allocations fills the station. This puts the full-station refusal and the release-then-reuse timing of a freed slot a few cycles into each scenario. It also makes collisions between wildcard-class entries and pinned-class entries on the arithmetic ports frequent during the random phase. The small payload width still keeps every payload in a run distinct enough to identify which entry reached which port.

// File: rtl/issq_pkg.sv
package issq_pkg;

    localparam int NUM_PORTS = 6;
    localparam int CLS_W     = 4;

    typedef enum logic [CLS_W-1:0] {
        CLS_ALU   = 4'd0,
        CLS_VINT  = 4'd1,
        CLS_MUL64 = 4'd2,
        CLS_SHROT = 4'd3,
        CLS_FMUL  = 4'd4,
        CLS_FADD  = 4'd5,
        CLS_BR    = 4'd6,
        CLS_LD    = 4'd7,
        CLS_STA   = 4'd8,
        CLS_STD   = 4'd9
    } uop_class_e;

    typedef logic [NUM_PORTS-1:0] port_mask_t;

    // Ports a class may run on; bit n set = port n allowed.
    function automatic port_mask_t class_ports(input logic [CLS_W-1:0] c);
        port_mask_t m;
        case (uop_class_e'(c))
            CLS_ALU, CLS_VINT:  m = 6'b100011;
            CLS_MUL64, CLS_FMUL: m = 6'b000001;
            CLS_SHROT, CLS_FADD: m = 6'b000010;
            CLS_BR:             m = 6'b100000;
            CLS_LD:             m = 6'b000100;
            CLS_STA:            m = 6'b001000;
            CLS_STD:            m = 6'b010000;
            default:            m = '0;
        endcase
        return m;
    endfunction

    // Selection order: arithmetic ports first (0,1,5), then memory ports.
    function automatic int pick_port(input int k);
        case (k)
            0:       return 0;
            1:       return 1;
            2:       return 5;
            3:       return 2;
            4:       return 3;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/issq_free_slot.sv
module issq_free_slot #(
    parameter int ENTRIES = 8
) (
    input  logic [ENTRIES-1:0]         occupied,
    output logic [$clog2(ENTRIES)-1:0] slot,
    output logic                       any_free
);
    localparam int IDX_W = $clog2(ENTRIES);

    // Lowest-numbered empty slot wins.
    always_comb begin
        slot     = '0;
        any_free = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!occupied[i]) begin
                slot     = IDX_W'(i);
                any_free = 1'b1;
            end
        end
    end
endmodule

// File: rtl/issq_age_matrix.sv
module issq_age_matrix #(
    parameter int ENTRIES = 8
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              alloc_fire,
    input  logic [$clog2(ENTRIES)-1:0]        alloc_slot,
    output logic [ENTRIES-1:0][ENTRIES-1:0]   older
);
    // older[j][i] = 1 means slot j was allocated before slot i.
    logic [ENTRIES-1:0][ENTRIES-1:0] older_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            older_q <= '0;
        end else if (alloc_fire) begin
            for (int j = 0; j < ENTRIES; j++) begin
                older_q[alloc_slot][j] <= 1'b0;
                older_q[j][alloc_slot] <= (j != int'(alloc_slot));
            end
        end
    end

    assign older = older_q;

    // Two slots never claim to be older than each other (R7).
    for (genvar i = 0; i < ENTRIES; i++) begin : g_ai
        for (genvar j = i + 1; j < ENTRIES; j++) begin : g_aj
            assert_age_antisym_R7: assert property (@(posedge clk) disable iff (rst)
                !(older_q[i][j] && older_q[j][i]))
                else $error("age matrix claims mutual seniority");
        end
    end
endmodule

// File: rtl/issq_oldest_pick.sv
module issq_oldest_pick #(
    parameter int ENTRIES = 8
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [ENTRIES-1:0]              cand,
    input  logic [ENTRIES-1:0][ENTRIES-1:0] older,
    output logic [ENTRIES-1:0]              gnt
);
    for (genvar i = 0; i < ENTRIES; i++) begin : g_col
        logic [ENTRIES-1:0] senior;
        for (genvar j = 0; j < ENTRIES; j++) begin : g_row
            assign senior[j] = older[j][i];
        end
        assign gnt[i] = cand[i] & ~|(cand & senior);
    end

    assert_pick_onehot_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt))
        else $error("picker granted more than one entry");

    assert_pick_live_R7: assert property (@(posedge clk) disable iff (rst)
        (|cand) |-> (|gnt))
        else $error("picker found no oldest candidate");
endmodule

// File: rtl/uop_issue_sched.sv
module uop_issue_sched
    import issq_pkg::*;
#(
    parameter int ENTRIES   = 8,
    parameter int PAYLOAD_W = 16
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 alloc_valid,
    input  logic [CLS_W-1:0]                     alloc_class,
    input  logic [PAYLOAD_W-1:0]                 alloc_payload,
    output logic                                 alloc_ready,
    output logic [$clog2(ENTRIES)-1:0]           alloc_slot,
    input  logic [ENTRIES-1:0]                   entry_ready,
    input  logic [NUM_PORTS-1:0]                 iss_stall,
    output logic [NUM_PORTS-1:0]                 iss_valid,
    output logic [NUM_PORTS-1:0][PAYLOAD_W-1:0]  iss_payload
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0]                     valid_q;
    logic [CLS_W-1:0]                       cls_q [ENTRIES];
    logic [PAYLOAD_W-1:0]                   pay_q [ENTRIES];
    logic [ENTRIES-1:0][ENTRIES-1:0]        older;
    logic [NUM_PORTS-1:0][ENTRIES-1:0]      elig;
    logic [NUM_PORTS-1:0][ENTRIES-1:0]      gnt_eff;
    logic [ENTRIES-1:0]                     taken [NUM_PORTS+1];
    logic [ENTRIES-1:0]                     issued_mask;
    logic [NUM_PORTS-1:0][CLS_W-1:0]        iss_cls;
    logic [NUM_PORTS-1:0]                   route_ok;
    logic [ENTRIES-1:0][NUM_PORTS-1:0]      ent_ports;
    logic                                   alloc_fire;

    // Slot allocation
    issq_free_slot #(.ENTRIES(ENTRIES)) u_free (
        .occupied (valid_q),
        .slot     (alloc_slot),
        .any_free (alloc_ready)
    );

    assign alloc_fire = alloc_valid & alloc_ready;

    issq_age_matrix #(.ENTRIES(ENTRIES)) u_age (
        .clk        (clk),
        .rst        (rst),
        .alloc_fire (alloc_fire),
        .alloc_slot (alloc_slot),
        .older      (older)
    );

    // Per-port eligibility
    always_comb begin
        port_mask_t m;
        for (int i = 0; i < ENTRIES; i++) begin
            m = class_ports(cls_q[i]);
            for (int p = 0; p < NUM_PORTS; p++) begin
                elig[p][i] = valid_q[i] & entry_ready[i] & m[p];
            end
        end
    end

    // Port selection chain in fixed order
    assign taken[0] = '0;

    for (genvar k = 0; k < NUM_PORTS; k++) begin : g_port
        localparam int P = pick_port(k);
        logic [ENTRIES-1:0] cand;
        logic [ENTRIES-1:0] pick;

        assign cand = elig[P] & ~taken[k];

        issq_oldest_pick #(.ENTRIES(ENTRIES)) u_pick (
            .clk   (clk),
            .rst   (rst),
            .cand  (cand),
            .older (older),
            .gnt   (pick)
        );

        assign gnt_eff[P]   = iss_stall[P] ? '0 : pick;
        assign taken[k+1]   = taken[k] | gnt_eff[P];
    end

    assign issued_mask = taken[NUM_PORTS];

    // Output muxes
    always_comb begin
        for (int p = 0; p < NUM_PORTS; p++) begin
            iss_valid[p]   = |gnt_eff[p];
            iss_payload[p] = '0;
            iss_cls[p]     = '0;
            for (int i = 0; i < ENTRIES; i++) begin
                if (gnt_eff[p][i]) begin
                    iss_payload[p] = iss_payload[p] | pay_q[i];
                    iss_cls[p]     = iss_cls[p] | cls_q[i];
                end
            end
        end
    end

    // Station state
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (alloc_fire && alloc_slot == IDX_W'(i)) begin
                    valid_q[i] <= 1'b1;
                end else if (issued_mask[i]) begin
                    valid_q[i] <= 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (alloc_fire) begin
            cls_q[alloc_slot] <= alloc_class;
            pay_q[alloc_slot] <= alloc_payload;
        end
    end

    // Checks
    always_comb begin
        port_mask_t m;
        for (int p = 0; p < NUM_PORTS; p++) begin
            m = class_ports(iss_cls[p]);
            route_ok[p] = m[p];
        end
        for (int i = 0; i < ENTRIES; i++) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                ent_ports[i][p] = gnt_eff[p][i];
            end
        end
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pchk
        // Class routing, covers R3 R4 R5 R6
        assert_class_route_R3: assert property (@(posedge clk) disable iff (rst)
            iss_valid[p] |-> route_ok[p])
            else $error("class issued on a port it may not use");

        assert_stall_quiet_R9: assert property (@(posedge clk) disable iff (rst)
            iss_stall[p] |-> !iss_valid[p])
            else $error("stalled port issued");

        assert_issued_ready_R10: assert property (@(posedge clk) disable iff (rst)
            iss_valid[p] |-> (|(gnt_eff[p] & entry_ready & valid_q)))
            else $error("issued entry not ready or not present");
    end

    for (genvar i = 0; i < ENTRIES; i++) begin : g_echk
        assert_single_port_R2: assert property (@(posedge clk) disable iff (rst)
            $onehot0(ent_ports[i]))
            else $error("entry issued on two ports");

        assert_release_R11: assert property (@(posedge clk) disable iff (rst)
            (issued_mask[i] && !(alloc_fire && alloc_slot == IDX_W'(i))) |=> !valid_q[i])
            else $error("issued entry still held");
    end

    assert_slot_free_R1: assert property (@(posedge clk) disable iff (rst)
        alloc_fire |-> !valid_q[alloc_slot])
        else $error("allocation into an occupied slot");

    assert_full_refuse_R1: assert property (@(posedge clk) disable iff (rst)
        (&valid_q) |-> !alloc_ready)
        else $error("allocation offered while full");
endmodule

// File: tb/uop_issue_sched_tb_top.sv
`timescale 1ns/1ps
module uop_issue_sched_tb_top;
    localparam int ENT = 4;
    localparam int PW  = 12;
    localparam int NP  = 6;

    localparam int C_ALU = 0, C_VINT = 1, C_MUL64 = 2, C_SHROT = 3, C_FMUL = 4;
    localparam int C_FADD = 5, C_BR = 6, C_LD = 7, C_STA = 8, C_STD = 9;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic                   alloc_valid;
    logic [3:0]             alloc_class;
    logic [PW-1:0]          alloc_payload;
    logic                   alloc_ready;
    logic [1:0]             alloc_slot;
    logic [ENT-1:0]         entry_ready;
    logic [NP-1:0]          iss_stall;
    logic [NP-1:0]          iss_valid;
    logic [NP-1:0][PW-1:0]  iss_payload;

    uop_issue_sched #(.ENTRIES(ENT), .PAYLOAD_W(PW)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .alloc_valid   (alloc_valid),
        .alloc_class   (alloc_class),
        .alloc_payload (alloc_payload),
        .alloc_ready   (alloc_ready),
        .alloc_slot    (alloc_slot),
        .entry_ready   (entry_ready),
        .iss_stall     (iss_stall),
        .iss_valid     (iss_valid),
        .iss_payload   (iss_payload)
    );

    typedef struct {
        int    port;
        bit    v;
        int    pay;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    event mon_ev;

    // Reference model of the station
    bit mv [ENT];
    int mc [ENT];
    int mp [ENT];
    int ms [ENT];
    int seq = 0;
    int pay_ctr = 1;

    function automatic bit bench_elig(int c, int p);
        case (c)
            0, 1:    return (p == 0) || (p == 1) || (p == 5);
            2, 4:    return p == 0;
            3, 5:    return p == 1;
            6:       return p == 5;
            7:       return p == 2;
            8:       return p == 3;
            9:       return p == 4;
            default: return 1'b0;
        endcase
    endfunction

    function automatic int ord(int k);
        case (k)
            0: return 0;
            1: return 1;
            2: return 5;
            3: return 2;
            4: return 3;
            default: return 4;
        endcase
    endfunction

    task automatic chk(bit ok, string tag, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    // Driver: drives one cycle, predicts, pushes expectations
    task automatic cyc(bit av, int acls, bit [ENT-1:0] rdy, bit [NP-1:0] stl, string tag);
        int best;
        int p;
        int freei;
        bit [ENT-1:0] tk;
        @(negedge clk);
        alloc_valid   = av;
        alloc_class   = 4'(acls);
        alloc_payload = PW'(pay_ctr);
        entry_ready   = rdy;
        iss_stall     = stl;
        #1;
        tk = '0;
        for (int k = 0; k < NP; k++) begin
            p = ord(k);
            best = -1;
            for (int i = 0; i < ENT; i++) begin
                if (mv[i] && rdy[i] && bench_elig(mc[i], p) && !tk[i]) begin
                    if (best < 0 || ms[i] < ms[best]) best = i;
                end
            end
            if (stl[p]) best = -1;
            if (best >= 0) tk[best] = 1'b1;
            exp_q.push_back('{p, best >= 0, (best >= 0) ? mp[best] : 0,
                              stl[p] ? "R9" : tag});
        end
        freei = -1;
        for (int i = ENT - 1; i >= 0; i--) if (!mv[i]) freei = i;
        chk(alloc_ready == (freei >= 0), (freei < 0) ? "R1" : tag, "alloc_ready",
            int'(alloc_ready), int'(freei >= 0));
        if (freei >= 0) chk(int'(alloc_slot) == freei, "R1", "alloc_slot",
                            int'(alloc_slot), freei);
        -> mon_ev;
        @(posedge clk);
        for (int i = 0; i < ENT; i++) if (tk[i]) mv[i] = 1'b0;
        if (av && freei >= 0) begin
            mv[freei] = 1'b1;
            mc[freei] = acls;
            mp[freei] = pay_ctr % (1 << PW);
            ms[freei] = seq;
            seq++;
        end
        pay_ctr++;
    endtask

    // Monitor: pops expectations and compares with the ports
    always @(mon_ev) begin
        for (int n = 0; n < NP; n++) begin
            exp_t e;
            e = exp_q.pop_front();
            chk(iss_valid[e.port] == e.v, e.tag, $sformatf("port %0d valid", e.port),
                int'(iss_valid[e.port]), int'(e.v));
            if (e.v)
                chk(int'(iss_payload[e.port]) == e.pay, e.tag,
                    $sformatf("port %0d payload", e.port),
                    int'(iss_payload[e.port]), e.pay);
        end
    end

    task automatic drain();
        for (int n = 0; n < 3; n++) cyc(1'b0, 0, '1, '0, "R11");
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        alloc_valid   = 1'b0;
        alloc_class   = '0;
        alloc_payload = '0;
        entry_ready   = '1;
        iss_stall     = '0;
        for (int i = 0; i < ENT; i++) mv[i] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12: reset state
        chk(alloc_ready == 1'b1, "R12", "alloc_ready in reset", int'(alloc_ready), 1);
        chk(iss_valid == '0, "R12", "iss_valid in reset", int'(iss_valid), 0);
        rst = 1'b0;
        #1;
        chk(iss_valid == '0, "R12", "iss_valid after reset", int'(iss_valid), 0);

        // R3/R6: memory and branch routing, full refusal (R1)
        cyc(1'b1, C_LD,  '0, '0, "R3");
        cyc(1'b1, C_STA, '0, '0, "R3");
        cyc(1'b1, C_STD, '0, '0, "R3");
        cyc(1'b1, C_BR,  '0, '0, "R6");
        cyc(1'b1, C_ALU, '1, '0, "R3");
        drain();

        // R4/R5: pinned arithmetic classes
        cyc(1'b1, C_MUL64, '0, '0, "R4");
        cyc(1'b1, C_FMUL,  '0, '0, "R4");
        cyc(1'b1, C_SHROT, '0, '0, "R5");
        cyc(1'b1, C_FADD,  '0, '0, "R5");
        cyc(1'b0, 0, '1, '0, "R4");
        cyc(1'b0, 0, '1, '0, "R5");
        drain();

        // R8 / R7: wildcard entries spread oldest-first over 0,1,5
        cyc(1'b1, C_ALU,  '0, '0, "R8");
        cyc(1'b1, C_VINT, '0, '0, "R8");
        cyc(1'b1, C_ALU,  '0, '0, "R8");
        cyc(1'b1, C_MUL64, '0, '0, "R7");
        cyc(1'b0, 0, '1, '0, "R7");
        cyc(1'b0, 0, '1, '0, "R7");
        drain();

        // R9: stalled port 0, its pick moves on; pinned entry waits
        cyc(1'b1, C_ALU, '0, '0, "R9");
        cyc(1'b1, C_ALU, '0, '0, "R9");
        cyc(1'b0, 0, '1, 6'b000001, "R9");
        cyc(1'b1, C_FMUL, '0, '0, "R9");
        cyc(1'b0, 0, '1, 6'b000001, "R9");
        cyc(1'b0, 0, '1, 6'b000001, "R9");
        cyc(1'b0, 0, '1, '0, "R9");
        drain();

        // R10: not-ready entry is skipped even though older
        cyc(1'b1, C_ALU, '0, '0, "R10");
        cyc(1'b1, C_ALU, '0, '0, "R10");
        cyc(1'b0, 0, 4'b0010, '0, "R10");
        cyc(1'b0, 0, 4'b0000, '0, "R10");
        cyc(1'b0, 0, 4'b0001, '0, "R10");
        drain();

        // R11: slot freed by issue is reusable only from the next cycle
        for (int n = 0; n < ENT; n++) cyc(1'b1, C_ALU, '0, '0, "R11");
        cyc(1'b1, C_BR, 4'b0001, '0, "R11");
        cyc(1'b1, C_BR, 4'b0000, '0, "R11");
        cyc(1'b0, 0, '1, '0, "R11");
        drain();

        // R2: random mix of classes, readiness and stalls
        for (int n = 0; n < 600; n++) begin
            cyc(1'($urandom % 2), int'($urandom % 11), ENT'($urandom),
                (($urandom % 4) == 0) ? NP'($urandom) : '0, "R2");
        end
        drain();
        drain();
        finish_run();
    end
endmodule